// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler Unit

This block holds an 8-bit timer and a watchdog timer that share one prescaler counter. A configuration input picks the owner of that counter. When the timer owns it, the counter divides the timer's count events. When the watchdog owns it, the counter stretches the watchdog period. The two owners never use it at the same time. The timer counts either every cycle of the instruction clock or edges on an external pin, and the edge polarity is selectable. Each count passes through a two-stage pipeline before it reaches the timer register. The timer raises a sticky flag when it wraps.

The watchdog is built from a base counter of `WDT_W` bits that advances on every clock. Each time the base counter wraps, the block either emits a one-cycle time-out pulse directly or counts the wrap in the prescaler, depending on which side owns the prescaler. The prescaler has no port of its own. It is cleared only as a side effect: a timer write clears it while the timer owns it, and a watchdog clear clears it while the watchdog owns it.

Top module: `tmr_wdt_prescale`

## Requirements
- R1: After reset, `tmr_q` is 0, `ovf_flag` is 0 and `wdt_timeout` is 0.
- R2: A `tmr_wr` pulse loads `tmr_wdata` into `tmr_q` at that clock edge and discards any increments still in the pipeline. When counting one increment per cycle, the first increment after a write appears three edges after the write edge.
- R3: With `cfg_pre_wdt`=1, the prescaler belongs to the watchdog and the timer advances by one for every source event. After the write edge, `tmr_q` at edge n equals D + max(0, n-2) on the internal source.
- R4: With `cfg_pre_wdt`=0, ratio code r (0..7) divides the source events by 2^(r+1). After a write of D, `tmr_q` at edge n equals D + floor((n-2)/2^(r+1)) for n>=2.
- R5: While the timer owns the prescaler, a timer write clears the prescaler and a `wdt_clr` pulse leaves it untouched.
- R6: `cfg_ext_src`=0 counts every clock cycle. `cfg_ext_src`=1 counts edges of `cnt_pin`: rising edges when `cfg_fall_edge`=0 and falling edges when `cfg_fall_edge`=1.
- R7: `ovf_flag` is set on the increment that takes `tmr_q` from 0xFF to 0x00. It then stays set until a `flag_clr` pulse clears it. If a clear and a new overflow fall in the same cycle, the flag stays set.
- R8: With `cfg_pre_wdt`=0, `wdt_timeout` pulses for one cycle 2^WDT_W edges after a watchdog clear. With `cfg_pre_wdt`=1 and ratio code r, it pulses 2^WDT_W * 2^r edges after the clear.
- R9: `wdt_clr` restarts the watchdog base counter, and also clears the prescaler while the watchdog owns it. A clear issued before the period ends postpones the time-out. Timer writes do not disturb the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_src | input | 1 | 0: count clock cycles, 1: count pin edges |
| cfg_fall_edge | input | 1 | 0: rising pin edges, 1: falling pin edges |
| cfg_pre_wdt | input | 1 | 0: prescaler owned by timer, 1: by watchdog |
| cfg_ratio | input | 3 | Prescaler ratio code |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_wdata | input | 8 | Timer write data |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear command |
| cnt_pin | input | 1 | External count pin |
| tmr_q | output | 8 | Timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
Two collisions get directed tests. The first is a flag clear that lands on the same edge as a fresh 0xFF to 0x00 increment. The bench loads 0xFE, counts edges through the pipeline delay, and drives `flag_clr` on exactly the overflow edge. The flag must read 1 afterwards. The second is a timer write, or a watchdog clear, issued while the other side owns the prescaler. The bench judges it by timing: a later timer step, or a time-out landing on its computed edge, shows that the prescaler was not cleared.

// File: rtl/tmr_wdt_prescale.sv
module tmr_wdt_prescale #(
  parameter int TW    = 8,
  parameter int PW    = 8,
  parameter int RW    = 3,
  parameter int WDT_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ext_src,
  input  logic          cfg_fall_edge,
  input  logic          cfg_pre_wdt,
  input  logic [RW-1:0] cfg_ratio,
  input  logic          tmr_wr,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          flag_clr,
  input  logic          wdt_clr,
  input  logic          cnt_pin,
  output logic [TW-1:0] tmr_q,
  output logic          ovf_flag,
  output logic          wdt_timeout
);

  logic [2:0]       pin_s;
  logic [PW-1:0]    pre;
  logic [WDT_W-1:0] base;
  logic             inc_d1, inc_d2;

  logic ext_evt, src_evt, wrap, tick_t, tick_w, inc, set_ovf;
  logic [PW-1:0] mask_w, mask_t;

  assign mask_w  = PW'((32'd1 << cfg_ratio) - 32'd1);
  assign mask_t  = {mask_w[PW-2:0], 1'b1};
  assign ext_evt = cfg_fall_edge ? (~pin_s[1] & pin_s[2]) : (pin_s[1] & ~pin_s[2]);
  assign src_evt = cfg_ext_src ? ext_evt : 1'b1;
  assign wrap    = (&base) & ~wdt_clr;
  assign tick_t  = src_evt & (&(pre | ~mask_t));
  assign tick_w  = wrap & (&(pre | ~mask_w));
  assign inc     = cfg_pre_wdt ? src_evt : tick_t;
  assign set_ovf = inc_d2 & ~tmr_wr & (&tmr_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_s <= '0;
    else        pin_s <= {pin_s[1:0], cnt_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (!cfg_pre_wdt) begin
      if (tmr_wr)       pre <= '0;
      else if (src_evt) pre <= pre + 1'b1;
    end else begin
      if (wdt_clr)      pre <= '0;
      else if (wrap)    pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       base <= '0;
    else if (wdt_clr) base <= '0;
    else              base <= base + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wdt_timeout <= 1'b0;
    else        wdt_timeout <= cfg_pre_wdt ? tick_w : wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_d1 <= 1'b0;
      inc_d2 <= 1'b0;
      tmr_q  <= '0;
    end else if (tmr_wr) begin
      inc_d1 <= 1'b0;
      inc_d2 <= 1'b0;
      tmr_q  <= tmr_wdata;
    end else begin
      inc_d1 <= inc;
      inc_d2 <= inc_d1;
      if (inc_d2) tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= set_ovf | (ovf_flag & ~flag_clr);

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && inc_d2) |=> tmr_q == TW'($past(tmr_q) + 1'b1));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_d2 && !tmr_wr && tmr_q == {TW{1'b1}}) |=> (ovf_flag && tmr_q == '0));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R5
  pre_tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && !cfg_pre_wdt) |=> pre == '0);

  // R9
  pre_wdt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && cfg_pre_wdt) |=> (pre == '0 && base == '0));

  // R9
  wdt_clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout);

endmodule

// File: tb/tb_tmr_wdt_prescale.sv
module tb_tmr_wdt_prescale;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_src = 1'b0, cfg_fall_edge = 1'b0, cfg_pre_wdt = 1'b1;
  logic [2:0] cfg_ratio = 3'd0;
  logic tmr_wr = 1'b0, flag_clr = 1'b0, wdt_clr = 1'b0, cnt_pin = 1'b0;
  logic [7:0] tmr_wdata = 8'd0;
  logic [7:0] tmr_q;
  logic ovf_flag, wdt_timeout;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr_wdt_prescale dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_src(cfg_ext_src), .cfg_fall_edge(cfg_fall_edge),
    .cfg_pre_wdt(cfg_pre_wdt), .cfg_ratio(cfg_ratio), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .flag_clr(flag_clr), .wdt_clr(wdt_clr), .cnt_pin(cnt_pin), .tmr_q(tmr_q),
    .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout));

  typedef struct packed {
    logic       own_wdt;
    logic [2:0] r;
    logic [7:0] d;
    logic [15:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 3'd0, 8'd10,   16'd20,  8'd28},
    '{1'b0, 3'd0, 8'd0,    16'd20,  8'd9},
    '{1'b0, 3'd1, 8'd5,    16'd30,  8'd12},
    '{1'b0, 3'd2, 8'h20,   16'd50,  8'd38},
    '{1'b0, 3'd7, 8'h40,   16'd300, 8'd65},
    '{1'b0, 3'd3, 8'hF0,   16'd100, 8'd246}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int m);
    repeat (m) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tmr(input logic [7:0] d);
    tmr_wdata = d; tmr_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    tmr_wr = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_clr = 1'b1; @(posedge clk); @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic pulse_flag();
    flag_clr = 1'b1; @(posedge clk); @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 tmr", tmr_q, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 timeout", wdt_timeout, 0);
    @(negedge clk); rst_n = 1'b1;
    adv(2);

    for (int i = 0; i < 6; i++) begin
      cfg_pre_wdt = VECS[i].own_wdt; cfg_ratio = VECS[i].r;
      wr_tmr(VECS[i].d);
      adv(int'(VECS[i].n));
      chk(VECS[i].own_wdt ? "R3 direct count" : "R4 ratio", tmr_q, VECS[i].exp);
    end

    // R2 write-to-increment latency
    cfg_pre_wdt = 1'b1;
    wr_tmr(8'd50);
    adv(2); chk("R2 hold", tmr_q, 50);
    adv(1); chk("R2 first inc", tmr_q, 51);

    // R5 timer write clears prescaler; wdt_clr leaves it alone
    cfg_pre_wdt = 1'b0; cfg_ratio = 3'd2;
    adv(5);
    wr_tmr(8'd100);
    adv(9); chk("R5 write clears prescaler", tmr_q, 100);
    wr_tmr(8'd100);
    adv(4); pulse_wdt();
    adv(7); chk("R5 wdt_clr keeps prescaler", tmr_q, 101);

    // R7 overflow, stickiness, clear, collision
    cfg_pre_wdt = 1'b1;
    wr_tmr(8'hFE); pulse_flag();
    adv(2); chk("R7 before wrap", ovf_flag, 0);
    adv(1); chk("R7 wrap value", tmr_q, 0);
    chk("R7 set", ovf_flag, 1);
    adv(3); chk("R7 sticky", ovf_flag, 1);
    pulse_flag(); chk("R7 clear", ovf_flag, 0);
    wr_tmr(8'hFE); pulse_flag();
    adv(2); pulse_flag();
    chk("R7 set beats clear", ovf_flag, 1);

    // R6 external pin edges
    cfg_ext_src = 1'b1; cfg_fall_edge = 1'b0;
    wr_tmr(8'd0);
    for (int p = 0; p < 3; p++) begin
      cnt_pin = 1'b1; adv(4); cnt_pin = 1'b0; adv(4);
    end
    adv(10); chk("R6 rising count", tmr_q, 3);
    cnt_pin = 1'b1; adv(10); chk("R6 rising on rise", tmr_q, 4);
    cfg_fall_edge = 1'b1;
    wr_tmr(8'd0);
    adv(10); chk("R6 falling ignores high", tmr_q, 0);
    cnt_pin = 1'b0; adv(10); chk("R6 falling count", tmr_q, 1);
    cfg_ext_src = 1'b0;

    // R8 watchdog without postscaler
    cfg_pre_wdt = 1'b0;
    pulse_wdt();
    adv(15); chk("R8 early", wdt_timeout, 0);
    adv(1);  chk("R8 timeout", wdt_timeout, 1);

    // R9 clear postpones
    pulse_wdt();
    adv(9); pulse_wdt();
    adv(6); chk("R9 postponed", wdt_timeout, 0);
    adv(9); chk("R9 still quiet", wdt_timeout, 0);
    adv(1); chk("R9 late timeout", wdt_timeout, 1);

    // R8 / R9 watchdog with postscaler 1:4, timer write in between
    cfg_pre_wdt = 1'b1; cfg_ratio = 3'd2;
    pulse_wdt();
    adv(40); wr_tmr(8'd7);
    adv(22); chk("R8 post early", wdt_timeout, 0);
    adv(1);  chk("R9 post timeout", wdt_timeout, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule